// File: doc/BRIEF.md
# Reduction Processor Register File

This block holds the internal registers of a small expression-reduction processor. A micro-sequencer drives it through individual strobes, and no program can reach these registers. There are three 8-bit pointers into memory: the read pointer into the source expression (source index), the write pointer into the result (destination index) and the pointer into the function definitions (function index). A save register keeps a copy of the destination index so that the write position can be rolled back when a function call has to be deferred.

The block also holds a 4-bit argument counter, an 8-bit value register that works like an accumulator, a 4-bit machine-state register and a 4-bit classification register. The classification register packs a 3-bit symbol class from memory with the zero flag of the argument counter. A 2-bit select picks the memory address from the three pointers or from an argument address. The argument address is the source index plus a negative offset built from the value register.

Top module: `reduction_regfile`

## Requirements
- R1: On a clock edge with `rst` high, every register becomes zero except the argument counter, which becomes 4'b1111.
- R2: The source, destination and function indices each load `dataIn` on their set strobe and add one (modulo 256) on their increment strobe. If set and increment are both high, set wins. With neither strobe high, the index holds its value.
- R3: `riSet` copies the destination index (its value before the edge) into the save register. `diRestore` reloads the destination index from the save register and takes priority over `diSet` and `diInc`.
- R4: The argument counter loads `dataIn[3:0]` on `acSet` (set wins over `acInc`) and counts up by one on `acInc`, wrapping from 4'b1111 to 4'b0000. `acZero` is high exactly when the counter holds 4'b1111.
- R5: The state register loads `stateIn` on `sSet` and otherwise holds its value. 4'b0000 is the initial state and 4'b1111 is the finished state.
- R6: On `sczSet`, the classification register captures `{acZero, symClass}`: bit 3 is the zero flag from before the edge and bits 2:0 are the symbol class. Otherwise it holds.
- R7: The value register loads `dataIn` on `vSet` and clears on `vClr`. Clear takes priority over load.
- R8: `addrOut` is selected by `adrSel` with no delay: 0 gives the source index, 1 the destination index, 2 the function index.
- R9: With `adrSel` = 3, `addrOut` = (source index + {6'b111111, valueOut[1:0]}) mod 256. The offsets 3, 2 and 1 give source index −1, −2 and −3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 8 | Load data for indices, value register and argument counter |
| symClass | input | 3 | Symbol class from memory |
| stateIn | input | 4 | Next machine state |
| siSet | input | 1 | Load source index |
| siInc | input | 1 | Increment source index |
| diSet | input | 1 | Load destination index |
| diInc | input | 1 | Increment destination index |
| riSet | input | 1 | Save destination index |
| diRestore | input | 1 | Restore destination index from save register |
| fiSet | input | 1 | Load function index |
| fiInc | input | 1 | Increment function index |
| acSet | input | 1 | Load argument counter |
| acInc | input | 1 | Increment argument counter |
| vSet | input | 1 | Load value register |
| vClr | input | 1 | Clear value register |
| sSet | input | 1 | Load state register |
| sczSet | input | 1 | Load classification register |
| adrSel | input | 2 | Address source select |
| addrOut | output | 8 | Memory address |
| siOut | output | 8 | Source index, used as ALU operand |
| valueOut | output | 8 | Value register |
| acOut | output | 4 | Argument counter bits |
| acZero | output | 1 | Argument counter at logical zero |
| stateOut | output | 4 | State register |
| sczOut | output | 4 | Classification register |

## Verification
The hardest case to reach is a rollback. The save register cannot be read directly, so a useful test must save the destination index, move it away with loads and increments, restore it, and then observe it through the address select. The directed sequences do exactly this, and they also drive the argument counter across its wrap so that the zero flag is sampled into the classification register on both sides of the wrap. Random strobe mixes with a random address select, checked every cycle against a bench model, cover the priority conflicts and every offset of the argument address.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int IDX_W = 8;
  localparam int AC_W  = 4;
  localparam int ST_W  = 4;
  localparam int CLS_W = 3;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_FUN = 2'd2,
    SEL_ARG = 2'd3
  } addrSel_e;

  typedef enum logic [1:0] {
    IDX_HOLD = 2'd0,
    IDX_LOAD = 2'd1,
    IDX_INC  = 2'd2,
    IDX_REST = 2'd3
  } idxOp_e;

  typedef struct packed {
    idxOp_e   siOp;
    idxOp_e   diOp;
    idxOp_e   fiOp;
    idxOp_e   acOp;
    logic     riLoad;
    logic     vLoad;
    logic     vClear;
    logic     sLoad;
    logic     sczLoad;
    addrSel_e sel;
  } rfCtrl_t;
endpackage

// File: rtl/rf_control.sv
module rf_control
  import rf_pkg::*;
(
  input  logic       siSet,
  input  logic       siInc,
  input  logic       diSet,
  input  logic       diInc,
  input  logic       riSet,
  input  logic       diRestore,
  input  logic       fiSet,
  input  logic       fiInc,
  input  logic       acSet,
  input  logic       acInc,
  input  logic       vSet,
  input  logic       vClr,
  input  logic       sSet,
  input  logic       sczSet,
  input  logic [1:0] adrSel,
  output rfCtrl_t    ctrl
);
  function automatic idxOp_e pick(input logic setS, input logic incS);
    if (setS)      return IDX_LOAD;
    else if (incS) return IDX_INC;
    else           return IDX_HOLD;
  endfunction

  always_comb begin
    ctrl.siOp    = pick(siSet, siInc);
    ctrl.fiOp    = pick(fiSet, fiInc);
    ctrl.acOp    = pick(acSet, acInc);
    ctrl.diOp    = diRestore ? IDX_REST : pick(diSet, diInc);
    ctrl.riLoad  = riSet;
    ctrl.vClear  = vClr;
    ctrl.vLoad   = vSet & ~vClr;
    ctrl.sLoad   = sSet;
    ctrl.sczLoad = sczSet;
    ctrl.sel     = addrSel_e'(adrSel);
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int AW = AC_W,
  parameter int SW = ST_W,
  parameter int CW = CLS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  rfCtrl_t       ctrl,
  input  logic [IW-1:0] dataIn,
  input  logic [CW-1:0] symClass,
  input  logic [SW-1:0] stateIn,
  output logic [IW-1:0] addrOut,
  output logic [IW-1:0] siOut,
  output logic [IW-1:0] valueOut,
  output logic [AW-1:0] acOut,
  output logic          acZero,
  output logic [SW-1:0] stateOut,
  output logic [CW:0]   sczOut
);
  localparam int NIDX = 3;
  localparam logic [IW-1:0] ONE_IDX = {{(IW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] ONE_AC  = {{(AW-1){1'b0}}, 1'b1};

  logic [IW-1:0] idxQ [NIDX];
  idxOp_e        idxOp [NIDX];
  logic [IW-1:0] riQ;
  logic [IW-1:0] vQ;
  logic [AW-1:0] acQ;
  logic [SW-1:0] sQ;
  logic [CW:0]   sczQ;
  logic [IW-1:0] argOffset;

  assign idxOp[0] = ctrl.siOp;
  assign idxOp[1] = ctrl.diOp;
  assign idxOp[2] = ctrl.fiOp;

  for (genvar g = 0; g < NIDX; g++) begin : gIdx
    always_ff @(posedge clk) begin
      if (rst) idxQ[g] <= '0;
      else begin
        unique case (idxOp[g])
          IDX_LOAD: idxQ[g] <= dataIn;
          IDX_INC:  idxQ[g] <= idxQ[g] + ONE_IDX;
          IDX_REST: idxQ[g] <= riQ;
          default:  idxQ[g] <= idxQ[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      riQ  <= '0;
      vQ   <= '0;
      acQ  <= '1;
      sQ   <= '0;
      sczQ <= '0;
    end else begin
      if (ctrl.riLoad) riQ <= idxQ[1];
      if (ctrl.vClear)     vQ <= '0;
      else if (ctrl.vLoad) vQ <= dataIn;
      unique case (ctrl.acOp)
        IDX_LOAD: acQ <= dataIn[AW-1:0];
        IDX_INC:  acQ <= acQ + ONE_AC;
        default:  acQ <= acQ;
      endcase
      if (ctrl.sLoad)   sQ   <= stateIn;
      if (ctrl.sczLoad) sczQ <= {acZero, symClass};
    end
  end

  assign argOffset = {{(IW-2){1'b1}}, vQ[1:0]};

  always_comb begin
    unique case (ctrl.sel)
      SEL_SRC: addrOut = idxQ[0];
      SEL_DST: addrOut = idxQ[1];
      SEL_FUN: addrOut = idxQ[2];
      default: addrOut = idxQ[0] + argOffset;
    endcase
  end

  assign siOut    = idxQ[0];
  assign valueOut = vQ;
  assign acOut    = acQ;
  assign acZero   = &acQ;
  assign stateOut = sQ;
  assign sczOut   = sczQ;
endmodule

// File: rtl/reduction_regfile.sv
module reduction_regfile
  import rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] dataIn,
  input  logic [2:0] symClass,
  input  logic [3:0] stateIn,
  input  logic       siSet,
  input  logic       siInc,
  input  logic       diSet,
  input  logic       diInc,
  input  logic       riSet,
  input  logic       diRestore,
  input  logic       fiSet,
  input  logic       fiInc,
  input  logic       acSet,
  input  logic       acInc,
  input  logic       vSet,
  input  logic       vClr,
  input  logic       sSet,
  input  logic       sczSet,
  input  logic [1:0] adrSel,
  output logic [7:0] addrOut,
  output logic [7:0] siOut,
  output logic [7:0] valueOut,
  output logic [3:0] acOut,
  output logic       acZero,
  output logic [3:0] stateOut,
  output logic [3:0] sczOut
);
  rfCtrl_t ctrl;

  rf_control u_ctrl (
    .siSet(siSet), .siInc(siInc), .diSet(diSet), .diInc(diInc),
    .riSet(riSet), .diRestore(diRestore), .fiSet(fiSet), .fiInc(fiInc),
    .acSet(acSet), .acInc(acInc), .vSet(vSet), .vClr(vClr),
    .sSet(sSet), .sczSet(sczSet), .adrSel(adrSel), .ctrl(ctrl)
  );

  rf_datapath #(.IW(8), .AW(4), .SW(4), .CW(3)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dataIn(dataIn),
    .symClass(symClass), .stateIn(stateIn), .addrOut(addrOut),
    .siOut(siOut), .valueOut(valueOut), .acOut(acOut), .acZero(acZero),
    .stateOut(stateOut), .sczOut(sczOut)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] dataIn,
  input logic [2:0] symClass,
  input logic       siSet,
  input logic       siInc,
  input logic       acSet,
  input logic       acInc,
  input logic       vClr,
  input logic       sSet,
  input logic       sczSet,
  input logic [1:0] adrSel,
  input logic [7:0] addrOut,
  input logic [7:0] siOut,
  input logic [7:0] valueOut,
  input logic [3:0] acOut,
  input logic       acZero,
  input logic [3:0] stateOut,
  input logic [3:0] sczOut
);
  assert_reset_values_R1: assert property (@(posedge clk)
    rst |=> (acOut == 4'hF && stateOut == 4'h0 && valueOut == 8'h00 && sczOut == 4'h0));

  assert_si_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
    siSet |=> siOut == $past(dataIn));

  assert_si_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (!siSet && siInc) |=> siOut == $past(siOut) + 8'd1);

  assert_ac_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (acInc && !acSet && acZero) |=> (acOut == 4'h0 && !acZero));

  assert_state_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !sSet |=> $stable(stateOut));

  assert_scz_capture_R6: assert property (@(posedge clk) disable iff (rst)
    sczSet |=> sczOut == {$past(acZero), $past(symClass)});

  assert_v_clear_R7: assert property (@(posedge clk) disable iff (rst)
    vClr |=> valueOut == 8'h00);

  assert_arg_addr_R9: assert property (@(posedge clk) disable iff (rst)
    adrSel == 2'd3 |-> addrOut == siOut + {6'b111111, valueOut[1:0]});
endmodule

bind reduction_regfile rf_checker u_chk (
  .clk(clk), .rst(rst), .dataIn(dataIn), .symClass(symClass),
  .siSet(siSet), .siInc(siInc), .acSet(acSet), .acInc(acInc),
  .vClr(vClr), .sSet(sSet), .sczSet(sczSet), .adrSel(adrSel),
  .addrOut(addrOut), .siOut(siOut), .valueOut(valueOut), .acOut(acOut),
  .acZero(acZero), .stateOut(stateOut), .sczOut(sczOut)
);

// File: tb/tb_reduction_regfile.sv
`timescale 1ns/1ps
module tb_reduction_regfile;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] dataIn = '0;
  logic [2:0] symClass = '0;
  logic [3:0] stateIn = '0;
  logic siSet = 0, siInc = 0, diSet = 0, diInc = 0, riSet = 0, diRestore = 0;
  logic fiSet = 0, fiInc = 0, acSet = 0, acInc = 0, vSet = 0, vClr = 0;
  logic sSet = 0, sczSet = 0;
  logic [1:0] adrSel = '0;
  logic [7:0] addrOut, siOut, valueOut;
  logic [3:0] acOut, stateOut, sczOut;
  logic acZero;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [7:0] mSi, mDi, mFi, mRi, mV;
  logic [3:0] mAc, mS, mScz;

  always #2 clk = ~clk;

  reduction_regfile dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expAddr(input logic [1:0] s);
    case (s)
      2'd0: return mSi;
      2'd1: return mDi;
      2'd2: return mFi;
      default: return mSi + {6'b111111, mV[1:0]};
    endcase
  endfunction

  task automatic modelStep();
    logic [7:0] nDi;
    logic zeroNow;
    zeroNow = (mAc == 4'hF);
    if (rst) begin
      mSi = 0; mDi = 0; mFi = 0; mRi = 0; mV = 0; mAc = 4'hF; mS = 0; mScz = 0;
      return;
    end
    if (diRestore)  nDi = mRi;
    else if (diSet) nDi = dataIn;
    else if (diInc) nDi = mDi + 8'd1;
    else            nDi = mDi;
    if (riSet) mRi = mDi;
    mDi = nDi;
    if (siSet) mSi = dataIn; else if (siInc) mSi = mSi + 8'd1;
    if (fiSet) mFi = dataIn; else if (fiInc) mFi = mFi + 8'd1;
    if (acSet) mAc = dataIn[3:0]; else if (acInc) mAc = mAc + 4'd1;
    if (vClr) mV = 0; else if (vSet) mV = dataIn;
    if (sSet) mS = stateIn;
    if (sczSet) mScz = {zeroNow, symClass};
  endtask

  task automatic clearStrobes();
    {siSet, siInc, diSet, diInc, riSet, diRestore, fiSet, fiInc} = '0;
    {acSet, acInc, vSet, vClr, sSet, sczSet} = '0;
  endtask

  // apply current inputs for one edge, then compare all outputs
  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check("R2 siOut", siOut, mSi);
    check("R4 acOut", acOut, mAc);
    check("R4 acZero", acZero, (mAc == 4'hF));
    check("R5 stateOut", stateOut, mS);
    check("R6 sczOut", sczOut, mScz);
    check("R7 valueOut", valueOut, mV);
    check(adrSel == 2'd3 ? "R9 argAddr" : "R8 addrOut", addrOut, expAddr(adrSel));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    @(negedge clk);
    rst = 1;
    tick();
    // R1 reset values
    check("R1 acOut reset", acOut, 4'hF);
    check("R1 stateOut reset", stateOut, 0);
    rst = 0;

    // R3 directed: save, move away, restore, observe via select 1
    clearStrobes(); adrSel = 2'd1; dataIn = 8'h5A; diSet = 1; tick();
    clearStrobes(); riSet = 1; diInc = 1; tick();
    clearStrobes(); dataIn = 8'hC3; diSet = 1; tick();
    check("R3 moved", addrOut, 8'hC3);
    clearStrobes(); diRestore = 1; diSet = 1; diInc = 1; tick();
    check("R3 restored", addrOut, 8'h5A);

    // R4/R6 directed: wrap of argument counter, zero flag captured either side
    clearStrobes(); dataIn = 8'h0E; acSet = 1; acInc = 1; tick();
    check("R4 set wins", acOut, 4'hE);
    clearStrobes(); acInc = 1; symClass = 3'd5; sczSet = 1; tick();
    check("R6 flag before zero", sczOut, 4'h5);
    clearStrobes(); acInc = 1; symClass = 3'd2; sczSet = 1; tick();
    check("R6 flag at zero", sczOut, 4'hA);
    check("R4 wrapped", acOut, 4'h0);

    // R7 clear beats load; R9 all offsets
    clearStrobes(); dataIn = 8'hFF; vSet = 1; vClr = 1; tick();
    check("R7 clear wins", valueOut, 0);
    clearStrobes(); dataIn = 8'h01; siSet = 1; adrSel = 2'd3; tick();
    for (int k = 0; k < 4; k++) begin
      clearStrobes(); dataIn = 8'(k); vSet = 1; tick();
      check("R9 wrap offset", addrOut, (8'h01 + 8'hFC + 8'(k)) & 8'hFF);
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      clearStrobes();
      dataIn = 8'($urandom); symClass = 3'($urandom); stateIn = 4'($urandom);
      adrSel = 2'($urandom);
      siSet = ($urandom % 5) == 0; siInc = ($urandom % 3) == 0;
      diSet = ($urandom % 5) == 0; diInc = ($urandom % 3) == 0;
      riSet = ($urandom % 6) == 0; diRestore = ($urandom % 8) == 0;
      fiSet = ($urandom % 5) == 0; fiInc = ($urandom % 3) == 0;
      acSet = ($urandom % 6) == 0; acInc = ($urandom % 2) == 0;
      vSet = ($urandom % 4) == 0; vClr = ($urandom % 7) == 0;
      sSet = ($urandom % 4) == 0; sczSet = ($urandom % 3) == 0;
      rst = ($urandom % 400) == 0;
      tick();
    end
    rst = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule